// File: doc/BRIEF.md
# Multi-Page Write Cache with Timed Page Programming

This block sits behind a serial slave front end and in front of a byte array held in registers. During a write transaction the front end passes a start address and then a stream of bytes. The block collects them in a cache of eight slots of eight bytes. Each slot records the target page and a mask of which bytes in it hold data. Byte n of a transaction goes to slot (n div 8) mod 8. Its target page is the start page plus that slot number, and its offset is the start offset plus n, taken modulo 8. A transaction longer than the cache therefore lands on the cache's earliest entries again and overwrites them.

When the front end reports a STOP that ends a write transaction with at least one byte loaded, the block programs each loaded slot into the array in slot order. Each slot costs `PAGE_CYCLES` clock cycles, and only the masked bytes change. While this is in progress, `busy` is high. The front end uses it to withhold acknowledges. The block also serves single-byte reads, which are answered one cycle after the request, but only while it is not busy.

The array has 2^`ADDR_W` bytes. The default of 11 keeps elaboration small. Setting `ADDR_W` to 13 gives the full 8192-byte array. Addresses split into a page number (upper bits) and a 3-bit offset (lower bits).

Top module: `page_cache_writer`

## Requirements
- R1: After reset, `busy` and `rd_valid` are low.
- R2: A read request while idle gives `rd_valid` high in the next cycle, with `rd_data` equal to the array byte at `rd_addr`.
- R3: A one-byte write followed by STOP raises `busy` in the cycle after STOP, for exactly `PAGE_CYCLES` cycles, and then the byte is in the array.
- R4: A write that loads k slots (k from 1 to 8) keeps `busy` high for k×`PAGE_CYCLES` cycles. Slot k holds bytes 8k to 8k+7 of the transaction and targets the start page plus k.
- R5: Within one slot, the offset wraps from 7 to 0 and stays on the same page.
- R6: Beyond 64 bytes, byte n and byte n+64 target the same location, and the later byte is the one programmed. `busy` lasts 8×`PAGE_CYCLES`.
- R7: Bytes of a page that the transaction did not write keep their previous values.
- R8: After `xfer_abort`, the loaded bytes are dropped. A later STOP starts no programming and the array is unchanged.
- R9: A STOP after a write start with no bytes loaded leaves `busy` low.
- R10: While busy, read requests give no `rd_valid`. Write starts, bytes and STOPs are ignored.
- R11: `busy` falls one cycle after the last slot is committed. A read issued in the last busy cycle is dropped. A read issued in the first idle cycle returns the newly programmed byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_start | input | 1 | Opens a write transaction at `wr_addr` |
| wr_addr | input | ADDR_W | Start byte address of the write |
| wr_byte_valid | input | 1 | One data byte of the open write |
| wr_data | input | 8 | Data byte |
| xfer_stop | input | 1 | STOP ends the transaction |
| xfer_abort | input | 1 | Transaction ended without STOP; drop cache |
| rd_req | input | 1 | Single-byte read request |
| rd_addr | input | ADDR_W | Read address |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 8 | Read data |
| busy | output | 1 | Programming in progress |

## Verification
The commit of the final slot and a read request can fall in the same cycle. Likewise, a new read can arrive in the very first cycle after `busy` drops. The bench issues a read on the last busy cycle and expects no `rd_valid`. It then issues a read on the first idle cycle and expects the scoreboard to receive the byte that the transaction had just programmed. During another programming run, the bench injects a read, a write start, a data byte and a STOP, and confirms that none of them takes effect.

// File: rtl/page_cache_writer.sv
module page_cache_writer #(
  parameter int ADDR_W      = 11,
  parameter int PAGE_BYTES  = 8,
  parameter int SLOTS       = 8,
  parameter int PAGE_CYCLES = 40000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_start,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic              wr_byte_valid,
  input  logic [7:0]        wr_data,
  input  logic              xfer_stop,
  input  logic              xfer_abort,
  input  logic              rd_req,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              rd_valid,
  output logic [7:0]        rd_data,
  output logic              busy
);
  localparam int OFF_W  = $clog2(PAGE_BYTES);
  localparam int SLOT_W = $clog2(SLOTS);
  localparam int PG_W   = ADDR_W - OFF_W;
  localparam int CNT_W  = OFF_W + SLOT_W;
  localparam int TMR_W  = $clog2(PAGE_CYCLES + 1);
  localparam int DEPTH  = 1 << ADDR_W;

  logic [7:0]            mem   [DEPTH];
  logic [7:0]            cdata [SLOTS][PAGE_BYTES];
  logic [PAGE_BYTES-1:0] cmask [SLOTS];
  logic [PG_W-1:0]       ctag  [SLOTS];

  logic [PG_W-1:0]  base_pg;
  logic [OFF_W-1:0] base_off;
  logic [CNT_W-1:0] cnt;
  logic             active;
  logic [TMR_W-1:0] tmr;
  logic [SLOT_W-1:0] ptr, nxt;
  logic             has_nxt;
  logic [SLOTS-1:0] loaded;

  genvar g;
  generate
    for (g = 0; g < SLOTS; g++) begin : g_loaded
      assign loaded[g] = |cmask[g];
    end
  endgenerate

  wire [SLOT_W-1:0] wr_slot = cnt[CNT_W-1:OFF_W];
  wire [OFF_W-1:0]  wr_off  = base_off + cnt[OFF_W-1:0];
  wire              take    = wr_byte_valid && active && !busy;
  wire              commit  = busy && (tmr == '0);

  always_comb begin
    nxt = '0;
    has_nxt = 1'b0;
    for (int s = SLOTS - 1; s >= 0; s--) begin
      if (loaded[s] && !(busy && SLOT_W'(s) == ptr)) begin
        nxt = SLOT_W'(s);
        has_nxt = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      active   <= 1'b0;
      cnt      <= '0;
      base_pg  <= '0;
      base_off <= '0;
      tmr      <= '0;
      ptr      <= '0;
      for (int s = 0; s < SLOTS; s++) cmask[s] <= '0;
    end else if (busy) begin
      if (tmr == '0) begin
        cmask[ptr] <= '0;
        if (has_nxt) begin
          ptr <= nxt;
          tmr <= TMR_W'(PAGE_CYCLES - 1);
        end else begin
          busy <= 1'b0;
        end
      end else begin
        tmr <= tmr - 1'b1;
      end
    end else if (xfer_abort) begin
      active <= 1'b0;
      for (int s = 0; s < SLOTS; s++) cmask[s] <= '0;
    end else if (wr_start) begin
      active   <= 1'b1;
      cnt      <= '0;
      base_pg  <= wr_addr[ADDR_W-1:OFF_W];
      base_off <= wr_addr[OFF_W-1:0];
      for (int s = 0; s < SLOTS; s++) cmask[s] <= '0;
    end else if (xfer_stop) begin
      active <= 1'b0;
      if (active && has_nxt) begin
        busy <= 1'b1;
        ptr  <= nxt;
        tmr  <= TMR_W'(PAGE_CYCLES - 1);
      end
    end else if (take) begin
      cnt <= cnt + 1'b1;
      cmask[wr_slot][wr_off] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (take && !xfer_abort && !wr_start && !xfer_stop) begin
      cdata[wr_slot][wr_off] <= wr_data;
      ctag[wr_slot] <= base_pg + PG_W'(wr_slot);
    end
  end

  always_ff @(posedge clk) begin
    if (commit) begin
      for (int b = 0; b < PAGE_BYTES; b++) begin
        if (cmask[ptr][b]) mem[{ctag[ptr], OFF_W'(b)}] <= cdata[ptr][b];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rd_valid <= 1'b0;
    else        rd_valid <= rd_req && !busy;
  end

  always_ff @(posedge clk) begin
    if (rd_req && !busy) rd_data <= mem[rd_addr];
  end
endmodule

// File: rtl/page_cache_writer_chk.sv
module page_cache_writer_chk #(
  parameter int SLOTS       = 8,
  parameter int PAGE_CYCLES = 40000
) (
  input logic clk,
  input logic rst_n,
  input logic busy,
  input logic xfer_stop,
  input logic rd_req,
  input logic rd_valid,
  input logic commit
);
  int run;

  always_ff @(posedge clk) begin
    if (!rst_n)    run <= 0;
    else if (busy) run <= run + 1;
    else           run <= 0;
  end

  assert_read_blocked_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && busy) |=> !rd_valid);

  assert_rdvalid_source_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(rd_req));

  assert_busy_after_stop_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(xfer_stop));

  assert_busy_length_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (run != 0 && (run % PAGE_CYCLES) == 0 && run <= SLOTS * PAGE_CYCLES));

  assert_fall_after_commit_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(commit));
endmodule

bind page_cache_writer page_cache_writer_chk #(
  .SLOTS(SLOTS), .PAGE_CYCLES(PAGE_CYCLES)
) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .xfer_stop(xfer_stop),
  .rd_req(rd_req), .rd_valid(rd_valid), .commit(commit)
);

// File: tb/test_page_cache_writer.sv
module test_page_cache_writer;
  localparam int AW = 11;
  localparam int PC = 12;

  logic clk = 0, rst_n = 0;
  logic wr_start = 0, wr_byte_valid = 0, xfer_stop = 0, xfer_abort = 0, rd_req = 0;
  logic [AW-1:0] wr_addr = '0, rd_addr = '0;
  logic [7:0] wr_data = '0;
  logic rd_valid, busy;
  logic [7:0] rd_data;

  int checks = 0, fails = 0;
  logic [7:0] model [1 << AW];
  logic [7:0] expq [$];
  string tagq [$];
  logic [AW-1:0] pa [$];
  logic [7:0] pd [$];
  logic [AW-1:0] base;
  int nbytes;

  always #4 clk = ~clk;

  page_cache_writer #(.ADDR_W(AW), .PAGE_CYCLES(PC)) i_page_cache_writer (
    .clk(clk), .rst_n(rst_n), .wr_start(wr_start), .wr_addr(wr_addr),
    .wr_byte_valid(wr_byte_valid), .wr_data(wr_data), .xfer_stop(xfer_stop),
    .xfer_abort(xfer_abort), .rd_req(rd_req), .rd_addr(rd_addr),
    .rd_valid(rd_valid), .rd_data(rd_data), .busy(busy));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    #2;
    if (rd_valid) begin
      checks++;
      if (expq.size() == 0) begin
        fails++;
        $display("FAIL R2 actual=%0h expected=no read", rd_data);
      end else begin
        logic [7:0] e;
        string t;
        e = expq.pop_front();
        t = tagq.pop_front();
        if (rd_data !== e) begin
          fails++;
          $display("FAIL %s actual=%0h expected=%0h", t, rd_data, e);
        end
      end
    end
  end

  task automatic do_read(input logic [AW-1:0] a, input string req);
    expq.push_back(model[a]);
    tagq.push_back(req);
    rd_req = 1; rd_addr = a;
    @(negedge clk);
    rd_req = 0;
  endtask

  task automatic begin_write(input logic [AW-1:0] a);
    wr_start = 1; wr_addr = a;
    @(negedge clk);
    wr_start = 0;
    base = a; nbytes = 0;
    pa.delete(); pd.delete();
  endtask

  task automatic put_byte(input logic [7:0] d);
    logic [AW-4:0] pg;
    logic [2:0] off;
    pg  = base[AW-1:3] + (AW-3)'((nbytes >> 3) & 7);
    off = base[2:0] + 3'(nbytes);
    pa.push_back({pg, off}); pd.push_back(d);
    nbytes++;
    wr_byte_valid = 1; wr_data = d;
    @(negedge clk);
    wr_byte_valid = 0;
  endtask

  task automatic finish_write(input int pages, input string req, input bit inject);
    int cnt;
    xfer_stop = 1;
    @(negedge clk);
    xfer_stop = 0;
    cnt = 0;
    while (busy && cnt < 200) begin
      cnt++;
      if (inject) begin
        if (cnt == 2) begin rd_req = 1; rd_addr = 0; end
        if (cnt == 3) begin
          rd_req = 0;
          check(rd_valid == 0, "R10 read during busy", rd_valid, 0);
          wr_start = 1; wr_addr = 0;
        end
        if (cnt == 4) begin wr_start = 0; wr_byte_valid = 1; wr_data = 8'hEE; end
        if (cnt == 5) begin wr_byte_valid = 0; xfer_stop = 1; end
        if (cnt == 6) xfer_stop = 0;
        if (cnt == pages * PC) begin rd_req = 1; rd_addr = pa[0]; end
      end
      @(negedge clk);
    end
    if (inject) begin
      rd_req = 0;
      check(rd_valid == 0, "R11 read in last busy cycle", rd_valid, 0);
    end
    check(cnt == pages * PC, req, cnt, pages * PC);
    for (int i = 0; i < pa.size(); i++) model[pa[i]] = pd[i];
  endtask

  task automatic expect_idle(input string req);
    xfer_stop = 1;
    @(negedge clk);
    xfer_stop = 0;
    check(busy == 0, req, busy, 0);
    @(negedge clk);
    check(busy == 0, req, busy, 0);
  endtask

  initial begin
    #1200000;
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(busy == 0, "R1 busy", busy, 0);
    check(rd_valid == 0, "R1 rd_valid", rd_valid, 0);
    rst_n = 1;
    @(negedge clk);

    // R4: fill eight pages from address 0
    begin_write(0);
    for (int i = 0; i < 64; i++) put_byte(8'(i ^ 8'h3C));
    finish_write(8, "R4 eight page time", 0);
    do_read(0, "R11 first idle read");
    for (int i = 1; i < 64; i += 9) do_read(AW'(i), "R4 page data");

    // R3 and R7: single byte in a filled page
    begin_write(5);
    put_byte(8'hA5);
    finish_write(1, "R3 single byte time", 0);
    do_read(5, "R3 byte");
    do_read(4, "R7 neighbour low");
    do_read(6, "R7 neighbour high");

    // R5: offset wrap within one page
    begin_write(6);
    for (int i = 0; i < 4; i++) put_byte(8'(8'h50 + i));
    finish_write(1, "R5 one page time", 0);
    for (int i = 0; i < 8; i++) do_read(AW'(i), "R5 wrap");

    // R4: two slots from an unaligned start, with R10/R11 injection
    begin_write(11'h013);
    for (int i = 0; i < 12; i++) put_byte(8'(8'h80 + i));
    finish_write(2, "R4 two page time", 1);
    do_read(pa[0], "R11 first idle read");
    for (int i = 16; i < 32; i++) do_read(AW'(i), "R4 slot mapping");
    do_read(0, "R10 ignored write");
    expect_idle("R10 ignored start");

    // R6: overflow beyond 64 bytes
    begin_write(11'h100);
    for (int i = 0; i < 70; i++) put_byte(8'(8'hC0 ^ i));
    finish_write(8, "R6 eight page time", 0);
    for (int i = 0; i < 8; i++) do_read(AW'(11'h100 + i), "R6 overwrite");
    do_read(11'h13F, "R6 last slot");

    // R8: abort drops the cache
    begin_write(11'h100);
    for (int i = 0; i < 3; i++) put_byte(8'h11);
    xfer_abort = 1;
    @(negedge clk);
    xfer_abort = 0;
    expect_idle("R8 stop after abort");
    do_read(11'h100, "R8 array unchanged");
    do_read(11'h102, "R8 array unchanged");

    // R9: stop without bytes
    begin_write(11'h020);
    expect_idle("R9 empty write");

    repeat (3) @(negedge clk);
    check(expq.size() == 0, "R2 all reads answered", expq.size(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule